// File: doc/BRIEF.md
# NAND Bus Cycle Timing Sequencer

This block turns single host requests into timed bus cycles on an asynchronous NAND flash interface. Each request names a cycle kind (command, address or data), a direction and a write value. The block runs that request through a fixed series of phases. Each phase has its own programmable length. It drives chip enable, the command latch, the address latch and the write and read strobes. It drives the data bus on writes and latches the returned word at the end of a read strobe.

Two configuration words set up the block. The control word enables the bank, sets the bus width, allows stalling on the flash busy line, and holds two small delays. One delay applies to a read that follows a command, the other to a read that follows an address. The timing word sets the setup, strobe, hold and bus-release lengths. A host sequencer feeds requests one at a time, waits for the done pulse, and builds flash operations out of these cycles.

Top module: `nand_cycle_seq`

## Requirements
- R1: After reset the bank is disabled: `req_ready`, `done`, `nand_cle`, `nand_ale` and `nand_dq_oe` are low, `nand_ce_n`, `nand_we_n` and `nand_re_n` are high, and `rdata` is zero. The timing fields reset to setup 0, strobe 6, hold 4 and release 0.
- R2: The bank is active only when control bit 2 (enable) is 1, bit 3 (NAND device) is 1 and bit 0 (bank reset) is 0. While it is inactive, `req_ready` stays low and every strobe stays inactive from the next cycle on.
- R3: Control bit 1 enables busy stalling and bit 4 selects a 16-bit bus (0 = 8-bit). Bits 12:9 hold the command-to-read delay and bits 16:13 hold the address-to-read delay. The timing word holds setup in 7:0, strobe in 15:8, hold in 23:16 and release in 31:24.
- R4: An access holds chip enable low for setup+1 cycles, then strobe+1 cycles with the strobe low, then hold cycles (none when hold is 0). After that, `req_ready` stays low for release cycles.
- R5: `req_type` 0 is a command cycle and raises `nand_cle`. Type 1 is an address cycle and raises `nand_ale`. Types 2 and 3 are data cycles and raise neither. The raised latch covers every cycle in which chip enable is low.
- R6: Command and address cycles are always writes. A write pulses `nand_we_n` and drives `nand_dq_oe` while chip enable is low. A data read pulses `nand_re_n` and never drives the bus.
- R7: In 16-bit mode the full word is driven and captured. In 8-bit mode only the low byte is, and the upper byte of `nand_dq_out` and `rdata` is zero.
- R8: `rdata` takes the bus value sampled at the last strobe cycle of a read and keeps it until the next read.
- R9: `done` is a one-cycle pulse in the first cycle after the hold phase of each access, or after the strobe phase when hold is 0.
- R10: A data read that follows a completed command cycle waits the command-to-read delay, in cycles, before chip enable falls. One that follows an address cycle waits the address-to-read delay. Other accesses have no such gap.
- R11: With busy stalling enabled, a data read does not start while `nand_rb` is low. It proceeds once the synchronised line is high. Writes are never stalled, and with stalling disabled `nand_rb` is ignored.
- R12: `req_ready` is high only while the bank is active and no access is in progress, so it is low from acceptance until the release phase ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_load | input | 1 | Load `ctrl_word` into the control fields |
| ctrl_word | input | 32 | Control word |
| tim_load | input | 1 | Load `tim_word` into the timing fields |
| tim_word | input | 32 | Timing word |
| req_valid | input | 1 | Request present |
| req_type | input | 2 | 0 command, 1 address, 2/3 data |
| req_write | input | 1 | Data direction for data cycles (1 = write) |
| req_wdata | input | DQ_W | Value to drive on writes |
| req_ready | output | 1 | Request accepted on this edge when high with `req_valid` |
| done | output | 1 | Access completion pulse |
| rdata | output | DQ_W | Last captured read value |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | DQ_W | Bus output value |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_in | input | DQ_W | Bus input value |
| nand_rb | input | 1 | Ready/busy line, high = ready |

## Verification
The bench builds the block with a 16-bit data path, a two-stage busy synchroniser and the default 8-bit timing fields and 4-bit delay fields. Because the 16-bit build selects the bus width at run time, one instance covers both the full-word path and the low-byte path. The wide timing fields allow the default lengths, short lengths and a zero hold to be measured from the strobes. The two-stage synchroniser gives a stall that lasts several cycles, so the bench can watch it before the busy line is released.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

   // field widths of the two configuration words
   localparam int CTRL_W = 32;
   localparam int TIM_W  = 32;
   localparam int TF_W   = 8;
   localparam int DLY_W  = 4;

   // control word bit positions
   localparam int BIT_BRST = 0;
   localparam int BIT_WAIT = 1;
   localparam int BIT_EN   = 2;
   localparam int BIT_NAND = 3;
   localparam int BIT_WIDE = 4;
   localparam int CLE_LSB  = 9;
   localparam int ALE_LSB  = CLE_LSB + DLY_W;

   // timing word field positions
   localparam int SET_LSB  = 0;
   localparam int WT_LSB   = SET_LSB + TF_W;
   localparam int HLD_LSB  = WT_LSB + TF_W;
   localparam int HIZ_LSB  = HLD_LSB + TF_W;

   // timing values after reset
   localparam logic [TF_W-1:0] WAIT_RST = TF_W'(6);
   localparam logic [TF_W-1:0] HOLD_RST = TF_W'(4);

   typedef enum logic [1:0] {
      CYC_CMD  = 2'd0,
      CYC_ADDR = 2'd1,
      CYC_DATA = 2'd2
   } cyc_t;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_RBWAIT,
      PH_GAP,
      PH_SETUP,
      PH_STROBE,
      PH_HOLD,
      PH_HIZ
   } phase_t;

   function automatic cyc_t decode_type(input logic [1:0] code);
      if (code[1])      return CYC_DATA;
      else if (code[0]) return CYC_ADDR;
      else              return CYC_CMD;
   endfunction

endpackage

// File: rtl/nseq_cfg.sv
module nseq_cfg
   import nseq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_load,
   input  logic [CTRL_W-1:0] ctrl_word,
   input  logic              tim_load,
   input  logic [TIM_W-1:0]  tim_word,
   output logic              bank_active,
   output logic              wait_en,
   output logic              wide,
   output logic [DLY_W-1:0]  d_cle,
   output logic [DLY_W-1:0]  d_ale,
   output logic [TF_W-1:0]   t_setup,
   output logic [TF_W-1:0]   t_wait,
   output logic [TF_W-1:0]   t_hold,
   output logic [TF_W-1:0]   t_hiz
);

   logic brst_q, wait_q, en_q, nand_q, wide_q;
   logic [DLY_W-1:0] cle_q, ale_q;
   logic [TF_W-1:0]  set_q, wt_q, hld_q, hiz_q;

   logic unused_ctrl_bits;
   assign unused_ctrl_bits = ^{ctrl_word[CTRL_W-1:ALE_LSB+DLY_W],
                               ctrl_word[CLE_LSB-1:BIT_WIDE+1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         brst_q <= 1'b0;
         wait_q <= 1'b0;
         en_q   <= 1'b0;
         nand_q <= 1'b0;
         wide_q <= 1'b0;
         cle_q  <= '0;
         ale_q  <= '0;
      end else if (ctrl_load) begin
         brst_q <= ctrl_word[BIT_BRST];
         wait_q <= ctrl_word[BIT_WAIT];
         en_q   <= ctrl_word[BIT_EN];
         nand_q <= ctrl_word[BIT_NAND];
         wide_q <= ctrl_word[BIT_WIDE];
         cle_q  <= ctrl_word[CLE_LSB +: DLY_W];
         ale_q  <= ctrl_word[ALE_LSB +: DLY_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         set_q <= '0;
         wt_q  <= WAIT_RST;
         hld_q <= HOLD_RST;
         hiz_q <= '0;
      end else if (tim_load) begin
         set_q <= tim_word[SET_LSB +: TF_W];
         wt_q  <= tim_word[WT_LSB  +: TF_W];
         hld_q <= tim_word[HLD_LSB +: TF_W];
         hiz_q <= tim_word[HIZ_LSB +: TF_W];
      end
   end

   assign bank_active = en_q & nand_q & ~brst_q;
   assign wait_en     = wait_q;
   assign wide        = wide_q;
   assign d_cle       = cle_q;
   assign d_ale       = ale_q;
   assign t_setup     = set_q;
   assign t_wait      = wt_q;
   assign t_hold      = hld_q;
   assign t_hiz       = hiz_q;

endmodule

// File: rtl/nseq_sync.sv
module nseq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= d;
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/nseq_fsm.sv
module nseq_fsm
   import nseq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bank_active,
   input  logic             wait_en,
   input  logic             rb_ok,
   input  logic [TF_W-1:0]  t_setup,
   input  logic [TF_W-1:0]  t_wait,
   input  logic [TF_W-1:0]  t_hold,
   input  logic [TF_W-1:0]  t_hiz,
   input  logic [DLY_W-1:0] d_cle,
   input  logic [DLY_W-1:0] d_ale,
   input  logic             req_valid,
   input  logic [1:0]       req_type,
   input  logic             req_write,
   output logic             req_ready,
   output logic             accept,
   output phase_t           phase,
   output cyc_t             cur_type,
   output logic             cur_write,
   output logic             done,
   output logic             capture
);

   localparam int CNT_W = (TF_W > DLY_W) ? TF_W : DLY_W;

   phase_t           phase_q, phase_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   cyc_t             type_q, type_d, last_q, last_d;
   logic             wr_q, wr_d, done_q, done_d;
   logic [DLY_W-1:0] gap_q, gap_d, gap_pick;
   cyc_t             req_kind;
   logic             req_is_rd;
   phase_t           fin_phase;
   logic [CNT_W-1:0] fin_cnt;

   assign req_kind  = decode_type(req_type);
   assign req_is_rd = (req_kind == CYC_DATA) && !req_write;
   assign req_ready = bank_active && (phase_q == PH_IDLE);
   assign accept    = req_valid && req_ready;

   // delay before a read, picked from the kind of the last finished cycle
   always_comb begin
      gap_pick = '0;
      if (req_is_rd) begin
         case (last_q)
            CYC_CMD:  gap_pick = d_cle;
            CYC_ADDR: gap_pick = d_ale;
            default:  gap_pick = '0;
         endcase
      end
   end

   assign fin_phase = (t_hiz != '0) ? PH_HIZ : PH_IDLE;
   assign fin_cnt   = CNT_W'(t_hiz) - CNT_W'(1);

   always_comb begin
      phase_d = phase_q;
      cnt_d   = cnt_q;
      type_d  = type_q;
      wr_d    = wr_q;
      last_d  = last_q;
      gap_d   = gap_q;
      done_d  = 1'b0;
      case (phase_q)
         PH_IDLE: begin
            if (accept) begin
               type_d = req_kind;
               wr_d   = (req_kind != CYC_DATA) || req_write;
               gap_d  = gap_pick;
               if (req_is_rd && wait_en) begin
                  phase_d = PH_RBWAIT;
               end else if (gap_pick != '0) begin
                  phase_d = PH_GAP;
                  cnt_d   = CNT_W'(gap_pick) - CNT_W'(1);
               end else begin
                  phase_d = PH_SETUP;
                  cnt_d   = CNT_W'(t_setup);
               end
            end
         end
         PH_RBWAIT: begin
            if (rb_ok || !wait_en) begin
               if (gap_q != '0) begin
                  phase_d = PH_GAP;
                  cnt_d   = CNT_W'(gap_q) - CNT_W'(1);
               end else begin
                  phase_d = PH_SETUP;
                  cnt_d   = CNT_W'(t_setup);
               end
            end
         end
         PH_GAP: begin
            if (cnt_q == '0) begin
               phase_d = PH_SETUP;
               cnt_d   = CNT_W'(t_setup);
            end else begin
               cnt_d = cnt_q - CNT_W'(1);
            end
         end
         PH_SETUP: begin
            if (cnt_q == '0) begin
               phase_d = PH_STROBE;
               cnt_d   = CNT_W'(t_wait);
            end else begin
               cnt_d = cnt_q - CNT_W'(1);
            end
         end
         PH_STROBE: begin
            if (cnt_q == '0) begin
               if (t_hold != '0) begin
                  phase_d = PH_HOLD;
                  cnt_d   = CNT_W'(t_hold) - CNT_W'(1);
               end else begin
                  done_d  = 1'b1;
                  last_d  = type_q;
                  phase_d = fin_phase;
                  cnt_d   = fin_cnt;
               end
            end else begin
               cnt_d = cnt_q - CNT_W'(1);
            end
         end
         PH_HOLD: begin
            if (cnt_q == '0) begin
               done_d  = 1'b1;
               last_d  = type_q;
               phase_d = fin_phase;
               cnt_d   = fin_cnt;
            end else begin
               cnt_d = cnt_q - CNT_W'(1);
            end
         end
         PH_HIZ: begin
            if (cnt_q == '0) phase_d = PH_IDLE;
            else             cnt_d   = cnt_q - CNT_W'(1);
         end
         default: phase_d = PH_IDLE;
      endcase
      if (!bank_active) begin
         phase_d = PH_IDLE;
         done_d  = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         type_q  <= CYC_CMD;
         wr_q    <= 1'b0;
         last_q  <= CYC_DATA;
         gap_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         phase_q <= phase_d;
         cnt_q   <= cnt_d;
         type_q  <= type_d;
         wr_q    <= wr_d;
         last_q  <= last_d;
         gap_q   <= gap_d;
         done_q  <= done_d;
      end
   end

   assign phase     = phase_q;
   assign cur_type  = type_q;
   assign cur_write = wr_q;
   assign done      = done_q;
   assign capture   = (phase_q == PH_STROBE) && (cnt_q == '0) && !wr_q;

endmodule

// File: rtl/nseq_pins.sv
module nseq_pins
   import nseq_pkg::*;
#(
   parameter int DQ_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            accept,
   input  logic [DQ_W-1:0] req_wdata,
   input  phase_t          phase,
   input  cyc_t            cur_type,
   input  logic            cur_write,
   input  logic            capture,
   input  logic            wide,
   input  logic [DQ_W-1:0] dq_in,
   output logic            ce_n,
   output logic            cle,
   output logic            ale,
   output logic            we_n,
   output logic            re_n,
   output logic            dq_oe,
   output logic [DQ_W-1:0] dq_out,
   output logic [DQ_W-1:0] rdata
);

   localparam int LANE = 8;

   logic [DQ_W-1:0] wdata_q, rdata_q, rd_next;
   logic            in_access, strobing;

   assign in_access = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
   assign strobing  = (phase == PH_STROBE);

   assign ce_n  = !in_access;
   assign cle   = in_access && (cur_type == CYC_CMD);
   assign ale   = in_access && (cur_type == CYC_ADDR);
   assign we_n  = !(strobing && cur_write);
   assign re_n  = !(strobing && !cur_write);
   assign dq_oe = in_access && cur_write;

   generate
      if (DQ_W > LANE) begin : g_wide_bus
         assign dq_out  = wide ? wdata_q : {{(DQ_W-LANE){1'b0}}, wdata_q[LANE-1:0]};
         assign rd_next = wide ? dq_in   : {{(DQ_W-LANE){1'b0}}, dq_in[LANE-1:0]};
      end else begin : g_byte_bus
         logic unused_wide;
         assign unused_wide = wide;
         assign dq_out  = wdata_q;
         assign rd_next = dq_in;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      wdata_q <= '0;
      else if (accept) wdata_q <= req_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rdata_q <= '0;
      else if (capture) rdata_q <= rd_next;
   end

   assign rdata = rdata_q;

endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
   import nseq_pkg::*;
#(
   parameter int DQ_W      = 16,
   parameter int RB_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_load,
   input  logic [CTRL_W-1:0] ctrl_word,
   input  logic              tim_load,
   input  logic [TIM_W-1:0]  tim_word,
   input  logic              req_valid,
   input  logic [1:0]        req_type,
   input  logic              req_write,
   input  logic [DQ_W-1:0]   req_wdata,
   output logic              req_ready,
   output logic              done,
   output logic [DQ_W-1:0]   rdata,
   output logic              nand_ce_n,
   output logic              nand_cle,
   output logic              nand_ale,
   output logic              nand_we_n,
   output logic              nand_re_n,
   output logic [DQ_W-1:0]   nand_dq_out,
   output logic              nand_dq_oe,
   input  logic [DQ_W-1:0]   nand_dq_in,
   input  logic              nand_rb
);

   generate
      if (DQ_W != 8 && DQ_W != 16) begin : g_bad_width
         initial $error("nand_cycle_seq: DQ_W must be 8 or 16");
      end
      if (RB_STAGES < 1) begin : g_bad_sync
         initial $error("nand_cycle_seq: RB_STAGES must be at least 1");
      end
   endgenerate

   logic             bank_active, wait_en, wide, rb_ok, accept, capture, cur_write;
   logic [DLY_W-1:0] d_cle, d_ale;
   logic [TF_W-1:0]  t_setup, t_wait, t_hold, t_hiz;
   phase_t           phase;
   cyc_t             cur_type;

   nseq_cfg u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl_load  (ctrl_load),
      .ctrl_word  (ctrl_word),
      .tim_load   (tim_load),
      .tim_word   (tim_word),
      .bank_active(bank_active),
      .wait_en    (wait_en),
      .wide       (wide),
      .d_cle      (d_cle),
      .d_ale      (d_ale),
      .t_setup    (t_setup),
      .t_wait     (t_wait),
      .t_hold     (t_hold),
      .t_hiz      (t_hiz)
   );

   nseq_sync #(.STAGES(RB_STAGES)) u_rb (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (nand_rb),
      .q    (rb_ok)
   );

   nseq_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .bank_active(bank_active),
      .wait_en    (wait_en),
      .rb_ok      (rb_ok),
      .t_setup    (t_setup),
      .t_wait     (t_wait),
      .t_hold     (t_hold),
      .t_hiz      (t_hiz),
      .d_cle      (d_cle),
      .d_ale      (d_ale),
      .req_valid  (req_valid),
      .req_type   (req_type),
      .req_write  (req_write),
      .req_ready  (req_ready),
      .accept     (accept),
      .phase      (phase),
      .cur_type   (cur_type),
      .cur_write  (cur_write),
      .done       (done),
      .capture    (capture)
   );

   nseq_pins #(.DQ_W(DQ_W)) u_pins (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .req_wdata(req_wdata),
      .phase    (phase),
      .cur_type (cur_type),
      .cur_write(cur_write),
      .capture  (capture),
      .wide     (wide),
      .dq_in    (nand_dq_in),
      .ce_n     (nand_ce_n),
      .cle      (nand_cle),
      .ale      (nand_ale),
      .we_n     (nand_we_n),
      .re_n     (nand_re_n),
      .dq_oe    (nand_dq_oe),
      .dq_out   (nand_dq_out),
      .rdata    (rdata)
   );

endmodule

// File: rtl/nseq_chk.sv
module nseq_chk #(
   parameter int DQ_W = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            bank_active,
   input logic            req_ready,
   input logic            done,
   input logic [DQ_W-1:0] rdata,
   input logic            nand_ce_n,
   input logic            nand_cle,
   input logic            nand_ale,
   input logic            nand_we_n,
   input logic            nand_re_n,
   input logic            nand_dq_oe
);

   // R2
   bank_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bank_active |=> (nand_ce_n && nand_we_n && nand_re_n));

   // R6
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!nand_we_n && !nand_re_n));

   // R5
   latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(nand_cle && nand_ale));

   // R5
   latch_in_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (nand_cle || nand_ale) |-> !nand_ce_n);

   // R6
   drive_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !nand_we_n |-> nand_dq_oe);

   // R12
   ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> nand_ce_n);

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   done_after_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> nand_ce_n);

   // R8
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nand_re_n |=> $stable(rdata));

endmodule

bind nand_cycle_seq nseq_chk #(.DQ_W(DQ_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bank_active(bank_active),
   .req_ready  (req_ready),
   .done       (done),
   .rdata      (rdata),
   .nand_ce_n  (nand_ce_n),
   .nand_cle   (nand_cle),
   .nand_ale   (nand_ale),
   .nand_we_n  (nand_we_n),
   .nand_re_n  (nand_re_n),
   .nand_dq_oe (nand_dq_oe)
);

// File: tb/sim_nand_cycle_seq.sv
`timescale 1ns/1ps
module sim_nand_cycle_seq;

   localparam int DQ_W = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            ctrl_load = 1'b0;
   logic [31:0]     ctrl_word = '0;
   logic            tim_load = 1'b0;
   logic [31:0]     tim_word = '0;
   logic            req_valid = 1'b0;
   logic [1:0]      req_type = '0;
   logic            req_write = 1'b0;
   logic [DQ_W-1:0] req_wdata = '0;
   logic            req_ready, done;
   logic [DQ_W-1:0] rdata, nand_dq_out;
   logic            nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
   logic [DQ_W-1:0] nand_dq_in = '0;
   logic            nand_rb = 1'b1;

   int n_checks = 0;
   int n_fail = 0;

   // measurements of the last access
   int m_pre, m_ce, m_cle, m_ale, m_we, m_re, m_oe, m_done_n, m_done_idx, m_rdy_wait, m_rdy_early;
   logic [DQ_W-1:0] m_dq, m_rdata;

   always #4 clk = ~clk;

   nand_cycle_seq #(.DQ_W(DQ_W), .RB_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n),
      .ctrl_load(ctrl_load), .ctrl_word(ctrl_word),
      .tim_load(tim_load), .tim_word(tim_word),
      .req_valid(req_valid), .req_type(req_type), .req_write(req_write), .req_wdata(req_wdata),
      .req_ready(req_ready), .done(done), .rdata(rdata),
      .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
      .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
      .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
      .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] ctrl_val(input bit wt, input bit wd,
                                            input int dc, input int da);
      return 32'h0000_000C | (32'(wt) << 1) | (32'(wd) << 4) |
             (32'(dc) << 9) | (32'(da) << 13);
   endfunction

   task automatic load_ctrl(input logic [31:0] v);
      @(negedge clk);
      ctrl_word = v; ctrl_load = 1'b1;
      @(negedge clk);
      ctrl_load = 1'b0;
   endtask

   task automatic load_tim(input logic [7:0] hz, input logic [7:0] hd,
                           input logic [7:0] wt, input logic [7:0] st);
      @(negedge clk);
      tim_word = {hz, hd, wt, st}; tim_load = 1'b1;
      @(negedge clk);
      tim_load = 1'b0;
   endtask

   task automatic issue(input logic [1:0] ty, input logic wr, input logic [DQ_W-1:0] wd);
      int guard;
      guard = 0;
      @(negedge clk);
      while (!req_ready && guard < 1000) begin
         @(negedge clk);
         guard++;
      end
      req_valid = 1'b1; req_type = ty; req_write = wr; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic do_access(input logic [1:0] ty, input logic wr, input logic [DQ_W-1:0] wd);
      bit seen_ce, seen_done;
      issue(ty, wr, wd);
      m_pre = 0; m_ce = 0; m_cle = 0; m_ale = 0; m_we = 0; m_re = 0; m_oe = 0;
      m_done_n = 0; m_done_idx = -1; m_rdy_wait = 0; m_rdy_early = 0;
      m_dq = '0; m_rdata = '0;
      seen_ce = 1'b0; seen_done = 1'b0;
      for (int i = 0; i < 3000; i++) begin
         if (!nand_ce_n) begin m_ce++; seen_ce = 1'b1; end
         else if (!seen_ce && !seen_done) m_pre++;
         if (nand_cle) m_cle++;
         if (nand_ale) m_ale++;
         if (!nand_we_n) begin m_we++; m_dq = nand_dq_out; end
         if (!nand_re_n) m_re++;
         if (nand_dq_oe) m_oe++;
         if (done) begin
            m_done_n++;
            if (!seen_done) m_done_idx = i;
            seen_done = 1'b1;
            m_rdata = rdata;
         end
         if (seen_done && !req_ready) m_rdy_wait++;
         if (!seen_done && req_ready) m_rdy_early++;
         if (seen_done && req_ready) break;
         @(negedge clk);
      end
   endtask

   task automatic t_reset;
      @(negedge clk);
      check("R1 ready after reset", req_ready, 0);
      check("R1 done after reset", done, 0);
      check("R1 strobes after reset",
            {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe}, 6'b111000);
      check("R1 rdata after reset", rdata, 0);
   endtask

   task automatic t_defaults;
      load_ctrl(ctrl_val(0, 0, 0, 0));
      do_access(2'd0, 1'b0, 16'h0090);
      check("R1 default ce length", m_ce, 12);
      check("R1 default strobe length", m_we, 7);
      check("R5 cle covers access", m_cle, 12);
      check("R5 no ale on command", m_ale, 0);
      check("R6 command forced write, no re", m_re, 0);
      check("R6 oe on command", m_oe, 12);
      check("R9 one done", m_done_n, 1);
      check("R9 done position", m_done_idx, 12);
      check("R12 ready low during access", m_rdy_early, 0);
      check("R4 zero release", m_rdy_wait, 0);
      check("R7 command byte", m_dq, 16'h0090);
   endtask

   task automatic t_timing;
      load_tim(8'd3, 8'd1, 8'd3, 8'd2);
      do_access(2'd1, 1'b0, 16'h1234);
      check("R4 ce length", m_ce, 8);
      check("R4 strobe length", m_we, 4);
      check("R5 ale covers access", m_ale, 8);
      check("R5 no cle on address", m_cle, 0);
      check("R9 done after hold", m_done_idx, 8);
      check("R4 release length", m_rdy_wait, 3);
      check("R12 ready low before done", m_rdy_early, 0);
      check("R7 8-bit write low byte", m_dq, 16'h0034);
      load_tim(8'd0, 8'd0, 8'd1, 8'd0);
      do_access(2'd2, 1'b1, 16'h0055);
      check("R4 zero hold ce length", m_ce, 3);
      check("R9 done with zero hold", m_done_idx, 3);
      check("R3 data write has no latch", m_cle + m_ale, 0);
      load_tim(8'd0, 8'd4, 8'd6, 8'd0);
   endtask

   task automatic t_reads;
      nand_dq_in = 16'hA55A;
      do_access(2'd2, 1'b0, '0);
      check("R6 read strobe length", m_re, 7);
      check("R6 read no we", m_we, 0);
      check("R6 read no drive", m_oe, 0);
      check("R7 8-bit read low byte", m_rdata, 16'h005A);
      load_ctrl(ctrl_val(0, 1, 0, 0));
      do_access(2'd3, 1'b0, '0);
      check("R7 16-bit read", m_rdata, 16'hA55A);
      nand_dq_in = 16'h1111;
      repeat (5) @(negedge clk);
      check("R8 rdata held after read", rdata, 16'hA55A);
      do_access(2'd2, 1'b1, 16'hBEEF);
      check("R7 16-bit write word", m_dq, 16'hBEEF);
      check("R8 rdata kept over write", rdata, 16'hA55A);
      load_ctrl(ctrl_val(0, 0, 0, 0));
   endtask

   task automatic t_gaps;
      load_ctrl(ctrl_val(0, 0, 5, 3));
      do_access(2'd0, 1'b0, 16'h0030);
      do_access(2'd2, 1'b0, '0);
      check("R10 command-to-read gap", m_pre, 5);
      do_access(2'd1, 1'b0, 16'h0001);
      do_access(2'd2, 1'b0, '0);
      check("R10 address-to-read gap", m_pre, 3);
      do_access(2'd1, 1'b0, 16'h0002);
      do_access(2'd2, 1'b1, 16'h0003);
      check("R10 no gap on write", m_pre, 0);
      do_access(2'd2, 1'b0, '0);
      check("R10 no gap after data", m_pre, 0);
      load_ctrl(ctrl_val(0, 0, 0, 0));
   endtask

   task automatic t_busy;
      int bad, got;
      load_ctrl(ctrl_val(1, 0, 0, 0));
      nand_rb = 1'b0;
      do_access(2'd2, 1'b1, 16'h0007);
      check("R11 write not stalled", m_pre, 0);
      issue(2'd2, 1'b0, '0);
      bad = 0;
      for (int i = 0; i < 20; i++) begin
         if (!nand_ce_n || done || !nand_re_n) bad++;
         @(negedge clk);
      end
      check("R11 read stalled while busy", bad, 0);
      nand_rb = 1'b1;
      got = 0;
      for (int i = 0; i < 100; i++) begin
         if (done) got++;
         @(negedge clk);
      end
      check("R11 read resumes when ready", got, 1);
      load_ctrl(ctrl_val(0, 0, 0, 0));
      nand_rb = 1'b0;
      do_access(2'd2, 1'b0, '0);
      check("R11 busy ignored when disabled", m_pre, 0);
      check("R11 read completes when disabled", m_done_n, 1);
      nand_rb = 1'b1;
   endtask

   task automatic t_disable;
      load_ctrl(32'h0000_000D);
      @(negedge clk);
      check("R2 bank reset bit blocks", req_ready, 0);
      check("R2 strobes idle in bank reset", {nand_ce_n, nand_we_n, nand_re_n}, 3'b111);
      load_ctrl(32'h0000_0008);
      @(negedge clk);
      check("R2 enable bit clear blocks", req_ready, 0);
      load_ctrl(32'h0000_0004);
      @(negedge clk);
      check("R2 device type clear blocks", req_ready, 0);
      load_ctrl(32'h0000_000C);
      @(negedge clk);
      check("R12 ready when active and idle", req_ready, 1);
      issue(2'd0, 1'b0, 16'h00FF);
      repeat (2) @(negedge clk);
      load_ctrl(32'h0000_0001);
      @(negedge clk);
      check("R2 access dropped on disable", {nand_ce_n, nand_we_n, nand_re_n, req_ready}, 4'b1110);
      load_ctrl(32'h0000_000C);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_defaults();
      t_timing();
      t_reads();
      t_gaps();
      t_busy();
      t_disable();
      repeat (5) @(negedge clk);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule